// File: doc/BRIEF.md
# Palettized Display Register Block

This block holds the configuration of an 8-bit indexed-colour display engine and presents it to the pixel pipeline. A host reaches it through a simple 32-bit word bus with one request per cycle: a valid strobe, a write flag, a byte address and write data. Read data comes back one cycle after the request, qualified by a return strobe. The stored state includes a 256-colour lookup table, three cursor colours, a 512-word cursor bitmap and a set of scalar registers. The scalar registers hold the visible width, visible height, a control word, the frame start offset in video memory and the cursor location. A write to a dedicated address restores every piece of that state to zero.

The two tables have a second, read-only port. The pixel pipeline uses that port every pixel without stalling the bus. Each table entry sits on an 8-byte address stride. Width and height are exchanged with the host in scaled units. The control word's depth field is decoded into a bits-per-pixel figure. The block also owns the frame interrupt: the pipeline pulses `frame_done` at the end of each frame, and the next bus write drops the line again.

Top module: `fbctl_regs`

## Requirements
- R1: Addresses 0x800 to 0xFFF map to the colour table entry (address − 0x800) >> 3, so address bits 2:0 are ignored. A write stores data bits 23:0 (red 23:16, green 15:8, blue 7:0), and a bus read returns those 24 bits zero-extended.
- R2: Addresses 0x508 to 0x51F hold three cursor colours, indexed by (address − 0x508) >> 3, with the same 24-bit packing. They are readable over the bus and appear on `cur_pal`, with colour k at bits 24k+23:24k.
- R3: Addresses 0x1000 to 0x1FFF map to cursor bitmap word (address − 0x1000) >> 3. A write keeps data bits 15:0, and a read returns them zero-extended.
- R4: A write to 0x118 sets `disp_width` to the data shifted left by 2 (modulo 2^32). A read of 0x118 returns `disp_width` shifted right by 2.
- R5: A write to 0x150 sets `disp_height` to the data shifted right by 1. A read of 0x150 returns `disp_height` shifted left by 1.
- R6: Address 0x300 holds the control word, which is readable and appears on `ctrl_word`. Bit 10 drives `force_blank` and bit 23 drives `cursor_off`. Bits 22:20 select `depth_bpp` by value: 0→1, 1→2, 2→4, 3→8, 4→15, 5→16, 6→0, 7→0.
- R7: A write to 0x400 sets `top_offset` and a write to 0x638 sets `cursor_pos`. Bus reads of both addresses return 0.
- R8: The pixel read ports return the entry addressed in one cycle on the following cycle. A bus write to a table entry is visible there from the cycle after the write.
- R9: A write to 0x100000 zeroes the colour table, cursor colours, cursor bitmap, width, height, control, top offset and cursor location, and lowers `irq`. The zeroing is visible on the cycle after the write.
- R10: Writes to the timing addresses (0x000, 0x108, 0x110, 0x120 to 0x148 and 0x158 to 0x170 in steps of 8, and 0x200) change no stored value. Bus reads of any address not named in R1–R6 return 0.
- R11: `frame_done` raises `irq` on the next cycle. Any other bus write lowers it on the next cycle. When `frame_done` and a non-reset write arrive together, `frame_done` wins. Otherwise `irq` holds its value.
- R12: A read request produces `bus_rvalid` high with its data exactly one cycle later. `bus_rdata` is 0 whenever `bus_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 21 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data return strobe |
| frame_done | input | 1 | End-of-frame pulse from the pixel pipeline |
| irq | output | 1 | Frame interrupt |
| pal_raddr | input | 8 | Pixel-side colour table index |
| pal_rgb | output | 24 | Colour table entry, one cycle later |
| pat_raddr | input | 9 | Pixel-side cursor bitmap index |
| pat_word | output | 16 | Cursor bitmap word, one cycle later |
| cur_pal | output | 72 | Three cursor colours |
| disp_width | output | 32 | Visible width in pixels |
| disp_height | output | 32 | Visible height in lines |
| ctrl_word | output | 32 | Control word |
| force_blank | output | 1 | Blanking request |
| cursor_off | output | 1 | Cursor disable |
| depth_bpp | output | 5 | Decoded bits per pixel |
| top_offset | output | 32 | Frame start offset in video memory |
| cursor_pos | output | 32 | Cursor location word |

## Verification
The hardest case to reach from the ports is a table entry after the soft reset. The zeroing comes from per-entry valid flags, not from rewriting 768 words, so a fault there shows only on entries that held data beforehand. The stimulus fills every colour entry and every bitmap word with distinct values, then issues the reset write. It then reads entries back through both the bus and pixel ports. A second subtle case is a write and `frame_done` in the same cycle. The bench drives that collision directly on one clock edge and checks the interrupt priority.

// File: rtl/fbctl_pkg.sv
package fbctl_pkg;

    localparam int CUR_COLOURS = 3;
    localparam int RGB_W       = 24;

    localparam int OFF_PAL_LO  = 'h800;
    localparam int OFF_CPAL_LO = 'h508;
    localparam int OFF_CPAL_HI = 'h51F;
    localparam int OFF_PAT_LO  = 'h1000;
    localparam int OFF_WIDTH   = 'h118;
    localparam int OFF_HEIGHT  = 'h150;
    localparam int OFF_CTRL    = 'h300;
    localparam int OFF_TOP     = 'h400;
    localparam int OFF_CPOS    = 'h638;
    localparam int OFF_SRST    = 'h100000;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_PAL,
        RG_CPAL,
        RG_PAT,
        RG_WIDTH,
        RG_HEIGHT,
        RG_CTRL,
        RG_TOP,
        RG_CPOS,
        RG_SRST,
        RG_TIMING
    } rgn_e;

    typedef struct packed {
        logic [31:0]                        width;
        logic [31:0]                        height;
        logic [31:0]                        ctrl;
        logic [31:0]                        top;
        logic [31:0]                        cpos;
        logic [CUR_COLOURS-1:0][RGB_W-1:0]  cpal;
        logic                               irq;
        logic                               rd_valid;
        rgn_e                               rd_sel;
        logic [31:0]                        rd_word;
    } regs_t;

    function automatic logic [4:0] depth_of(input logic [2:0] sel);
        logic [4:0] bpp;
        case (sel)
            3'd0:    bpp = 5'd1;
            3'd1:    bpp = 5'd2;
            3'd2:    bpp = 5'd4;
            3'd3:    bpp = 5'd8;
            3'd4:    bpp = 5'd15;
            3'd5:    bpp = 5'd16;
            default: bpp = 5'd0;
        endcase
        return bpp;
    endfunction

    function automatic logic is_timing(input int off);
        logic hit;
        hit = (off == 'h000) || (off == 'h108) || (off == 'h110) || (off == 'h200);
        if (off >= 'h120 && off <= 'h148 && (off % 8) == 0) hit = 1'b1;
        if (off >= 'h158 && off <= 'h170 && (off % 8) == 0) hit = 1'b1;
        return hit;
    endfunction

endpackage

// File: rtl/fbctl_decode.sv
module fbctl_decode
    import fbctl_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int PAL_DEPTH = 256,
    parameter int PAT_DEPTH = 512
) (
    input  logic [ADDR_W-1:0]            addr,
    output rgn_e                         rgn,
    output logic [$clog2(PAL_DEPTH)-1:0] pal_idx,
    output logic [$clog2(PAT_DEPTH)-1:0] pat_idx,
    output logic [1:0]                   cpal_idx
);
    localparam int PAL_AW = $clog2(PAL_DEPTH);
    localparam int PAT_AW = $clog2(PAT_DEPTH);
    localparam int PAL_HI = OFF_PAL_LO + PAL_DEPTH * 8;
    localparam int PAT_HI = OFF_PAT_LO + PAT_DEPTH * 8;

    int off;

    always_comb begin
        off      = int'(addr);
        pal_idx  = addr[3 +: PAL_AW];
        pat_idx  = addr[3 +: PAT_AW];
        cpal_idx = addr[4:3] - 2'd1;
        if (off >= OFF_PAL_LO && off < PAL_HI)              rgn = RG_PAL;
        else if (off >= OFF_PAT_LO && off < PAT_HI)         rgn = RG_PAT;
        else if (off >= OFF_CPAL_LO && off <= OFF_CPAL_HI)  rgn = RG_CPAL;
        else if (off == OFF_WIDTH)                          rgn = RG_WIDTH;
        else if (off == OFF_HEIGHT)                         rgn = RG_HEIGHT;
        else if (off == OFF_CTRL)                           rgn = RG_CTRL;
        else if (off == OFF_TOP)                            rgn = RG_TOP;
        else if (off == OFF_CPOS)                           rgn = RG_CPOS;
        else if (off == OFF_SRST)                           rgn = RG_SRST;
        else if (is_timing(off))                            rgn = RG_TIMING;
        else                                                rgn = RG_NONE;
    end

endmodule

// File: rtl/fbctl_ram.sv
module fbctl_ram #(
    parameter int WIDTH = 24,
    parameter int DEPTH = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     a_we,
    input  logic [$clog2(DEPTH)-1:0] a_addr,
    input  logic [WIDTH-1:0]         a_wdata,
    output logic [WIDTH-1:0]         a_rdata,
    input  logic [$clog2(DEPTH)-1:0] b_addr,
    output logic [WIDTH-1:0]         b_rdata
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [WIDTH-1:0] a_q, b_q;
    logic             a_v_q, b_v_q;

    always_ff @(posedge clk) begin
        if (a_we) mem[a_addr] <= a_wdata;
        a_q <= mem[a_addr];
        b_q <= mem[b_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            a_v_q <= 1'b0;
            b_v_q <= 1'b0;
        end else begin
            a_v_q <= vld_q[a_addr];
            b_v_q <= vld_q[b_addr];
            if (clr)       vld_q         <= '0;
            else if (a_we) vld_q[a_addr] <= 1'b1;
        end
    end

    assign a_rdata = a_v_q ? a_q : '0;
    assign b_rdata = b_v_q ? b_q : '0;

endmodule

// File: rtl/fbctl_regs.sv
module fbctl_regs
    import fbctl_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int PAL_DEPTH = 256,
    parameter int PAT_DEPTH = 512,
    parameter int PAT_W     = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_valid,
    input  logic                         bus_write,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    output logic                         bus_rvalid,
    input  logic                         frame_done,
    output logic                         irq,
    input  logic [$clog2(PAL_DEPTH)-1:0] pal_raddr,
    output logic [RGB_W-1:0]             pal_rgb,
    input  logic [$clog2(PAT_DEPTH)-1:0] pat_raddr,
    output logic [PAT_W-1:0]             pat_word,
    output logic [CUR_COLOURS*RGB_W-1:0] cur_pal,
    output logic [31:0]                  disp_width,
    output logic [31:0]                  disp_height,
    output logic [31:0]                  ctrl_word,
    output logic                         force_blank,
    output logic                         cursor_off,
    output logic [4:0]                   depth_bpp,
    output logic [31:0]                  top_offset,
    output logic [31:0]                  cursor_pos
);
    localparam int PAL_AW   = $clog2(PAL_DEPTH);
    localparam int PAT_AW   = $clog2(PAT_DEPTH);
    localparam int BLANK_B  = 10;
    localparam int NOCUR_B  = 23;
    localparam int DEPTH_LO = 20;

    regs_t s_d, s_q;

    rgn_e              rgn;
    logic [PAL_AW-1:0] pal_idx;
    logic [PAT_AW-1:0] pat_idx;
    logic [1:0]        cpal_idx;
    logic              wr, rd, srst;
    logic [RGB_W-1:0]  pal_a_rdata;
    logic [PAT_W-1:0]  pat_a_rdata;

    fbctl_decode #(
        .ADDR_W    (ADDR_W),
        .PAL_DEPTH (PAL_DEPTH),
        .PAT_DEPTH (PAT_DEPTH)
    ) u_decode (
        .addr     (bus_addr),
        .rgn      (rgn),
        .pal_idx  (pal_idx),
        .pat_idx  (pat_idx),
        .cpal_idx (cpal_idx)
    );

    assign wr   = bus_valid && bus_write;
    assign rd   = bus_valid && !bus_write;
    assign srst = wr && (rgn == RG_SRST);

    fbctl_ram #(.WIDTH(RGB_W), .DEPTH(PAL_DEPTH)) u_pal_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (srst),
        .a_we    (wr && (rgn == RG_PAL)),
        .a_addr  (pal_idx),
        .a_wdata (bus_wdata[RGB_W-1:0]),
        .a_rdata (pal_a_rdata),
        .b_addr  (pal_raddr),
        .b_rdata (pal_rgb)
    );

    fbctl_ram #(.WIDTH(PAT_W), .DEPTH(PAT_DEPTH)) u_pat_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (srst),
        .a_we    (wr && (rgn == RG_PAT)),
        .a_addr  (pat_idx),
        .a_wdata (bus_wdata[PAT_W-1:0]),
        .a_rdata (pat_a_rdata),
        .b_addr  (pat_raddr),
        .b_rdata (pat_word)
    );

    always_comb begin
        s_d          = s_q;
        s_d.rd_valid = 1'b0;
        s_d.rd_sel   = RG_NONE;
        s_d.rd_word  = '0;

        if (frame_done) s_d.irq = 1'b1;
        else if (wr)    s_d.irq = 1'b0;

        if (wr) begin
            case (rgn)
                RG_WIDTH:  s_d.width  = bus_wdata << 2;
                RG_HEIGHT: s_d.height = bus_wdata >> 1;
                RG_CTRL:   s_d.ctrl   = bus_wdata;
                RG_TOP:    s_d.top    = bus_wdata;
                RG_CPOS:   s_d.cpos   = bus_wdata;
                RG_CPAL: begin
                    if (int'(cpal_idx) < CUR_COLOURS)
                        s_d.cpal[cpal_idx] = bus_wdata[RGB_W-1:0];
                end
                RG_SRST: begin
                    s_d.width  = '0;
                    s_d.height = '0;
                    s_d.ctrl   = '0;
                    s_d.top    = '0;
                    s_d.cpos   = '0;
                    s_d.cpal   = '0;
                    s_d.irq    = 1'b0;
                end
                default: ;
            endcase
        end

        if (rd) begin
            s_d.rd_valid = 1'b1;
            s_d.rd_sel   = rgn;
            case (rgn)
                RG_WIDTH:  s_d.rd_word = s_q.width >> 2;
                RG_HEIGHT: s_d.rd_word = s_q.height << 1;
                RG_CTRL:   s_d.rd_word = s_q.ctrl;
                RG_CPAL: begin
                    if (int'(cpal_idx) < CUR_COLOURS)
                        s_d.rd_word = 32'(s_q.cpal[cpal_idx]);
                end
                default:   s_d.rd_word = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (s_q.rd_valid) begin
            case (s_q.rd_sel)
                RG_PAL:  bus_rdata = 32'(pal_a_rdata);
                RG_PAT:  bus_rdata = 32'(pat_a_rdata);
                default: bus_rdata = s_q.rd_word;
            endcase
        end
    end

    for (genvar k = 0; k < CUR_COLOURS; k++) begin : g_cpal_out
        assign cur_pal[k*RGB_W +: RGB_W] = s_q.cpal[k];
    end

    assign bus_rvalid  = s_q.rd_valid;
    assign irq         = s_q.irq;
    assign disp_width  = s_q.width;
    assign disp_height = s_q.height;
    assign ctrl_word   = s_q.ctrl;
    assign force_blank = s_q.ctrl[BLANK_B];
    assign cursor_off  = s_q.ctrl[NOCUR_B];
    assign depth_bpp   = depth_of(s_q.ctrl[DEPTH_LO +: 3]);
    assign top_offset  = s_q.top;
    assign cursor_pos  = s_q.cpos;

endmodule

// File: rtl/fbctl_regs_chk.sv
module fbctl_regs_chk
    import fbctl_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              bus_rvalid,
    input logic              frame_done,
    input logic              irq,
    input logic [31:0]       disp_width,
    input logic [31:0]       disp_height,
    input logic [31:0]       ctrl_word,
    input logic [31:0]       top_offset,
    input logic [31:0]       cursor_pos
);
    logic wr_c, srst_c;
    assign wr_c   = bus_valid && bus_write;
    assign srst_c = wr_c && (bus_addr == ADDR_W'(OFF_SRST));

    p_rvalid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> bus_rvalid);

    p_rdata_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rvalid |-> (bus_rdata == 32'd0));

    p_irq_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !srst_c) |=> irq);

    p_irq_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_c && !frame_done) |=> !irq);

    p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_done && !wr_c) |=> $stable(irq));

    p_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_c && bus_addr == ADDR_W'(OFF_WIDTH)) |=> (disp_width == ($past(bus_wdata) << 2)));

    p_height_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_c && bus_addr == ADDR_W'(OFF_HEIGHT)) |=> (disp_height == ($past(bus_wdata) >> 1)));

    p_srst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        srst_c |=> (disp_width == 0 && disp_height == 0 && ctrl_word == 0 &&
                    top_offset == 0 && cursor_pos == 0 && !irq));

endmodule

bind fbctl_regs fbctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .bus_rvalid  (bus_rvalid),
    .frame_done  (frame_done),
    .irq         (irq),
    .disp_width  (disp_width),
    .disp_height (disp_height),
    .ctrl_word   (ctrl_word),
    .top_offset  (top_offset),
    .cursor_pos  (cursor_pos)
);

// File: tb/fbctl_regs_bench.sv
module fbctl_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [20:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        frame_done = 1'b0;
    logic        irq;
    logic [7:0]  pal_raddr = '0;
    logic [23:0] pal_rgb;
    logic [8:0]  pat_raddr = '0;
    logic [15:0] pat_word;
    logic [71:0] cur_pal;
    logic [31:0] disp_width, disp_height, ctrl_word, top_offset, cursor_pos;
    logic        force_blank, cursor_off;
    logic [4:0]  depth_bpp;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fbctl_regs u_fbctl_regs (
        .clk (clk), .rst_n (rst_n),
        .bus_valid (bus_valid), .bus_write (bus_write), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .bus_rvalid (bus_rvalid),
        .frame_done (frame_done), .irq (irq),
        .pal_raddr (pal_raddr), .pal_rgb (pal_rgb),
        .pat_raddr (pat_raddr), .pat_word (pat_word), .cur_pal (cur_pal),
        .disp_width (disp_width), .disp_height (disp_height), .ctrl_word (ctrl_word),
        .force_blank (force_blank), .cursor_off (cursor_off), .depth_bpp (depth_bpp),
        .top_offset (top_offset), .cursor_pos (cursor_pos)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 21'(addr); bus_wdata = data;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 21'(addr);
        @(negedge clk);
        bus_valid = 1'b0;
        chk("R12 rvalid", 32'(bus_rvalid), 32'd1);
        data = bus_rdata;
    endtask

    function automatic logic [23:0] pal_val(input int i);
        logic [7:0] b = 8'(i);
        return {b, ~b, b ^ 8'h5A};
    endfunction

    function automatic logic [15:0] pat_val(input int i);
        return 16'(i * 37) ^ 16'h1234;
    endfunction

    function automatic logic [4:0] exp_bpp(input int sel);
        case (sel)
            0: return 5'd1;
            1: return 5'd2;
            2: return 5'd4;
            3: return 5'd8;
            4: return 5'd15;
            5: return 5'd16;
            default: return 5'd0;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] snap [5];
        int tmo [14] = '{'h000, 'h108, 'h110, 'h120, 'h128, 'h130, 'h138,
                         'h140, 'h148, 'h158, 'h160, 'h168, 'h170, 'h200};
        int wv [4] = '{0, 1, 'h12345678, 'hFFFFFFFF};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R11 reset irq", 32'(irq), 0);
        chk("R12 reset rvalid", 32'(bus_rvalid), 0);
        chk("R12 reset rdata", bus_rdata, 0);
        chk("R4 reset width", disp_width, 0);
        chk("R6 reset depth", 32'(depth_bpp), 1);

        // R1 colour table sweep, aliasing low address bits, plus R8 pixel port
        for (int i = 0; i < 256; i++)
            wr('h800 + i * 8 + (i % 8), {8'hA5, pal_val(i)});
        for (int i = 0; i < 256; i++) begin
            rd('h800 + i * 8 + ((i * 3) % 8), r);
            chk("R1 colour read", r, 32'(pal_val(i)));
            @(negedge clk);
            pal_raddr = 8'(i);
            @(negedge clk);
            chk("R8 colour pixel port", 32'(pal_rgb), 32'(pal_val(i)));
        end

        // R3 cursor bitmap sweep
        for (int i = 0; i < 512; i++)
            wr('h1000 + i * 8, {16'hBEEF, pat_val(i)});
        for (int i = 0; i < 512; i++) begin
            rd('h1000 + i * 8 + 4, r);
            chk("R3 bitmap read", r, 32'(pat_val(i)));
            @(negedge clk);
            pat_raddr = 9'(i);
            @(negedge clk);
            chk("R8 bitmap pixel port", 32'(pat_word), 32'(pat_val(i)));
        end

        // R8 write then pixel read on the very next cycle
        @(negedge clk);
        pal_raddr = 8'd77;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 21'('h800 + 77 * 8); bus_wdata = 32'h00C0FFEE;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        @(negedge clk);
        chk("R8 write-to-pixel latency", 32'(pal_rgb), 32'h00C0FFEE);

        // R2 cursor colours
        for (int k = 0; k < 3; k++) wr('h508 + k * 8, 32'hFF000000 | (32'h111111 * (k + 3)));
        for (int k = 0; k < 3; k++) begin
            rd('h508 + k * 8 + 7, r);
            chk("R2 cursor colour read", r, 32'h111111 * (k + 3));
            chk("R2 cursor colour port", 32'(cur_pal[k*24 +: 24]), 32'h111111 * (k + 3));
        end

        // R4 / R5 scaled width and height
        foreach (wv[j]) begin
            wr('h118, wv[j]);
            chk("R4 width port", disp_width, 32'(wv[j]) << 2);
            rd('h118, r);
            chk("R4 width read", r, 32'(wv[j]) & 32'h3FFFFFFF);
            wr('h150, wv[j]);
            chk("R5 height port", disp_height, 32'(wv[j]) >> 1);
            rd('h150, r);
            chk("R5 height read", r, 32'(wv[j]) & 32'hFFFFFFFE);
        end

        // R6 control sweep over the depth field
        for (int s = 0; s < 8; s++) begin
            logic [31:0] cw;
            cw = (32'(s) << 20) | (32'(s & 1) << 10) | (32'((s >> 1) & 1) << 23) | 32'h5;
            wr('h300, cw);
            chk("R6 depth", 32'(depth_bpp), 32'(exp_bpp(s)));
            chk("R6 blank", 32'(force_blank), 32'(s & 1));
            chk("R6 cursor off", 32'(cursor_off), 32'((s >> 1) & 1));
            rd('h300, r);
            chk("R6 control read", r, cw);
        end

        // R7 top offset and cursor location
        wr('h400, 32'h0003_2000);
        wr('h638, 32'h0012_3045);
        chk("R7 top port", top_offset, 32'h0003_2000);
        chk("R7 cursor port", cursor_pos, 32'h0012_3045);
        rd('h400, r); chk("R7 top read zero", r, 0);
        rd('h638, r); chk("R7 cursor read zero", r, 0);

        // R10 timing writes are ignored; unlisted reads give zero
        snap[0] = disp_width; snap[1] = disp_height; snap[2] = ctrl_word;
        snap[3] = top_offset; snap[4] = cursor_pos;
        foreach (tmo[j]) wr(tmo[j], 32'hDEAD0000 + 32'(j));
        chk("R10 width kept", disp_width, snap[0]);
        chk("R10 height kept", disp_height, snap[1]);
        chk("R10 ctrl kept", ctrl_word, snap[2]);
        chk("R10 top kept", top_offset, snap[3]);
        chk("R10 cursor kept", cursor_pos, snap[4]);
        chk("R10 cursor colour kept", 32'(cur_pal[23:0]), 32'h333333);
        rd('h000, r);  chk("R10 read timing zero", r, 0);
        rd('h2000, r); chk("R10 read unmapped zero", r, 0);
        rd('h7F8, r);  chk("R10 read gap zero", r, 0);

        // R11 interrupt behaviour
        @(negedge clk); frame_done = 1'b1;
        @(negedge clk); frame_done = 1'b0;
        chk("R11 irq raised", 32'(irq), 1);
        repeat (3) @(negedge clk);
        chk("R11 irq held", 32'(irq), 1);
        rd('h300, r);
        chk("R11 irq kept over read", 32'(irq), 1);
        wr('h108, 32'h0);
        chk("R11 irq cleared by write", 32'(irq), 0);
        @(negedge clk);
        frame_done = 1'b1;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 21'('h200); bus_wdata = 0;
        @(negedge clk);
        frame_done = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
        chk("R11 frame_done beats write", 32'(irq), 1);

        // R9 soft reset
        wr('h100000, 32'hFFFFFFFF);
        chk("R9 irq low", 32'(irq), 0);
        chk("R9 width", disp_width, 0);
        chk("R9 height", disp_height, 0);
        chk("R9 ctrl", ctrl_word, 0);
        chk("R9 top", top_offset, 0);
        chk("R9 cursor pos", cursor_pos, 0);
        chk("R9 cursor colours", 32'(|cur_pal), 0);
        rd('h800 + 5 * 8, r);   chk("R9 colour entry", r, 0);
        rd('h1000 + 9 * 8, r);  chk("R9 bitmap word", r, 0);
        rd('h510, r);           chk("R9 cursor colour read", r, 0);
        @(negedge clk); pal_raddr = 8'd200; pat_raddr = 9'd300;
        @(negedge clk);
        chk("R9 colour pixel port", 32'(pal_rgb), 0);
        chk("R9 bitmap pixel port", 32'(pat_word), 0);
        wr('h800 + 3 * 8, 32'h00ABCDEF);
        rd('h800 + 3 * 8, r);   chk("R1 write after reset", r, 32'h00ABCDEF);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule